// File: doc/BRIEF.md
# Configurable Lookup-Table Logic Block with Two Registers

This block is one programmable cell. Its core is a 32-entry truth table addressed by variables picked from seven candidates: the five block inputs and the outputs of the block's own two flip-flops. A two-bit mode field sets how the table is used:
- as one function of five variables;
- as two separate four-variable functions, one in each 16-entry half;
- as those two halves joined by a final multiplexer, whose select is a further chosen variable.

The last use reaches some functions of six or seven variables.

Each flip-flop takes its next value from the low-half result F, the high-half result G, or a shared data pin. Both flip-flops share one clock enable and one asynchronous clear. Each of the two outputs shows either a table result or its flip-flop. The whole setup (table bits, mode, address sources, register and output selects) is one 67-bit word. This word is shifted in serially, most significant bit first, while a configuration enable is high. The flip-flops are frozen during that time.

Top module: `lut_logic_block`

## Requirements
- R1: After a synchronous reset (`rst` high across a rising edge), the configuration word and both flip-flops are zero, so `x_out` and `y_out` read 0.
- R2: While `cfg_en` is high, each rising edge shifts the configuration word left by one and loads `cfg_din` into bit 0. After 67 shifts, the first bit sent sits in bit 66. Field layout: table [66:35] (address k at bit 35+k), mode [34:33], F-half sources [32:21] (source i at [23+3i:21+3i]), G-half sources [20:9] (source i at [11+3i:9+3i]), fifth/select source [8:6], X register select [5:4], Y register select [3:2], X output select [1], Y output select [0]. While `cfg_en` is low, the word does not change.
- R3: In mode 00, F and G both equal the table entry at address {select-source variable, F source 3, F source 2, F source 1, F source 0}.
- R4: In mode 01, F is the table entry at {0, F sources 3..0} and G is the entry at {1, G sources 3..0}.
- R5: In modes 01 and 10, address bits 0 and 1 of each half can only use source codes 0 to 4 (the block inputs). A code of 5, 6 or 7 on those bits drives 0.
- R6: In mode 10, F and G both equal the high-half result (as in R4) when the select-source variable is 1, and the low-half result otherwise.
- R7: Mode 11 behaves as mode 00.
- R8: Source codes: 0 to 4 pick `vin[0]` to `vin[4]`, 5 picks flip-flop QX, 6 picks flip-flop QY, and 7 drives 0.
- R9: On a rising edge with `ce` high and `cfg_en` low, each flip-flop loads according to its select: 00 loads F, 01 loads G, and 10 or 11 loads `dpin`. With `ce` low, the flip-flops hold.
- R10: `clr` high clears both flip-flops at once, without waiting for a clock edge.
- R11: While `cfg_en` is high, the flip-flops hold even if `ce` is high.
- R12: `x_out` shows QX when the X output select is 1 and F otherwise. `y_out` shows QY when the Y output select is 1 and G otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of configuration and registers |
| clr | input | 1 | Asynchronous clear of both flip-flops |
| cfg_en | input | 1 | Configuration shift enable; also freezes the flip-flops |
| cfg_din | input | 1 | Serial configuration data, most significant bit first |
| ce | input | 1 | Shared flip-flop clock enable |
| vin | input | 5 | Block inputs A (bit 0) to E (bit 4) |
| dpin | input | 1 | Direct data input for the flip-flops |
| x_out | output | 1 | F or QX |
| y_out | output | 1 | G or QY |

## Verification
Configuration shifting and the register clock enable can be active in the same cycle. The bench first sets QX to 1. It then holds `ce` high and `dpin` low through an entire 67-bit load whose new word routes QX to `x_out`. It judges the result by reading `x_out` after the load, which must still show 1.

Register feedback and the table lookup also share cycles: with QX and QY used as address variables, every register update changes the next lookup. The bench keeps its own model of both registers and checks every lookup against it.

// File: rtl/lutblk_pkg.sv
package lutblk_pkg;
  localparam int LUT_AW   = 5;
  localparam int LUT_N    = 1 << LUT_AW;
  localparam int HALF_AW  = LUT_AW - 1;
  localparam int N_IN     = 5;
  localparam int N_VAR    = N_IN + 2;
  localparam int SRC_W    = $clog2(N_VAR + 1);
  localparam int FIXED_IN = 2;

  typedef enum logic [1:0] {
    MODE_ONE   = 2'b00,
    MODE_SPLIT = 2'b01,
    MODE_MERGE = 2'b10,
    MODE_ALT   = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    D_FROM_F = 2'b00,
    D_FROM_G = 2'b01,
    D_PIN    = 2'b10,
    D_PIN_B  = 2'b11
  } dsel_e;

  typedef struct packed {
    logic [LUT_N-1:0]                  table_bits;
    mode_e                             mode;
    logic [HALF_AW-1:0][SRC_W-1:0]     src_f;
    logic [HALF_AW-1:0][SRC_W-1:0]     src_g;
    logic [SRC_W-1:0]                  src_m;
    dsel_e                             d_x;
    dsel_e                             d_y;
    logic                              x_reg;
    logic                              y_reg;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/lutblk_cfg_chain.sv
module lutblk_cfg_chain #(
  parameter int W = 67
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         sin,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)           q <= '0;
    else if (shift_en) q <= {q[W-2:0], sin};
  end

  // R2
  shift_in_chk: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> q[0] == $past(sin));
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(q));
endmodule

// File: rtl/lutblk_lut.sv
module lutblk_lut
  import lutblk_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  cfg_t            cfg,
  input  logic [N_IN-1:0] vin,
  input  logic            qx,
  input  logic            qy,
  output logic            f,
  output logic            g
);
  logic [N_VAR-1:0]   vars;
  logic [HALF_AW-1:0] fa, ga;
  logic               sv, split, lo, hi, full;

  function automatic logic pick(input logic [SRC_W-1:0] code,
                                input logic [N_VAR-1:0] v,
                                input logic restr);
    if (int'(code) >= N_VAR)               return 1'b0;
    else if (restr && int'(code) >= N_IN)  return 1'b0;
    else                                   return v[code];
  endfunction

  assign vars  = {qy, qx, vin};
  assign split = (cfg.mode == MODE_SPLIT) || (cfg.mode == MODE_MERGE);

  for (genvar i = 0; i < HALF_AW; i++) begin : g_addr
    localparam bit RESTR = (i < FIXED_IN);
    assign fa[i] = pick(cfg.src_f[i], vars, split && RESTR);
    assign ga[i] = pick(cfg.src_g[i], vars, split && RESTR);
  end

  assign sv   = pick(cfg.src_m, vars, 1'b0);
  assign lo   = cfg.table_bits[{1'b0, fa}];
  assign hi   = cfg.table_bits[{1'b1, ga}];
  assign full = cfg.table_bits[{sv, fa}];

  always_comb begin
    unique case (cfg.mode)
      MODE_SPLIT: begin f = lo; g = hi; end
      MODE_MERGE: begin f = sv ? hi : lo; g = f; end
      default:    begin f = full; g = full; end
    endcase
  end

  // R3
  joined_same_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg.mode != MODE_SPLIT) |-> (f == g));
endmodule

// File: rtl/lutblk_regs.sv
module lutblk_regs
  import lutblk_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  clr,
  input  logic  hold,
  input  logic  ce,
  input  logic  f,
  input  logic  g,
  input  logic  dpin,
  input  dsel_e sel_x,
  input  dsel_e sel_y,
  output logic  qx,
  output logic  qy
);
  logic dx, dy;

  function automatic logic dmux(input dsel_e s, input logic fv,
                                input logic gv, input logic pv);
    case (s)
      D_FROM_F: return fv;
      D_FROM_G: return gv;
      default:  return pv;
    endcase
  endfunction

  assign dx = dmux(sel_x, f, g, dpin);
  assign dy = dmux(sel_y, f, g, dpin);

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      qx <= 1'b0;
      qy <= 1'b0;
    end else if (rst) begin
      qx <= 1'b0;
      qy <= 1'b0;
    end else if (ce && !hold) begin
      qx <= dx;
      qy <= dy;
    end
  end

  // R9
  d_load_chk: assert property (@(posedge clk) disable iff (rst || clr)
    (ce && !hold) |=> (qx == $past(dx)) && (qy == $past(dy)));
  // R11
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst || clr)
    hold |=> $stable(qx) && $stable(qy));
  // R10
  clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr |-> (!qx && !qy));
endmodule

// File: rtl/lut_logic_block.sv
module lut_logic_block
  import lutblk_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            cfg_en,
  input  logic            cfg_din,
  input  logic            ce,
  input  logic [N_IN-1:0] vin,
  input  logic            dpin,
  output logic            x_out,
  output logic            y_out
);
  logic [CFG_W-1:0] cfg_q;
  cfg_t             cfg;
  logic             f, g, qx, qy;

  lutblk_cfg_chain #(.W(CFG_W)) u_chain (
    .clk(clk), .rst(rst), .shift_en(cfg_en), .sin(cfg_din), .q(cfg_q)
  );

  assign cfg = cfg_t'(cfg_q);

  lutblk_lut u_lut (
    .clk(clk), .rst(rst), .cfg(cfg), .vin(vin),
    .qx(qx), .qy(qy), .f(f), .g(g)
  );

  lutblk_regs u_regs (
    .clk(clk), .rst(rst), .clr(clr), .hold(cfg_en), .ce(ce),
    .f(f), .g(g), .dpin(dpin), .sel_x(cfg.d_x), .sel_y(cfg.d_y),
    .qx(qx), .qy(qy)
  );

  assign x_out = cfg.x_reg ? qx : f;
  assign y_out = cfg.y_reg ? qy : g;

  // R12
  out_reg_chk: assert property (@(posedge clk) disable iff (rst || clr)
    cfg.x_reg |-> (x_out == qx));
endmodule

// File: tb/lut_logic_block_test.sv
`timescale 1ns/1ps
module lut_logic_block_test;
  logic clk = 0, rst = 1, clr = 0, cfg_en = 0, cfg_din = 0, ce = 0, dpin = 0;
  logic [4:0] vin = 0;
  logic x_out, y_out;
  int checks = 0, errors = 0;
  logic [66:0] sh = '0;
  logic mqx = 0, mqy = 0;

  lut_logic_block uut (.clk(clk), .rst(rst), .clr(clr), .cfg_en(cfg_en),
    .cfg_din(cfg_din), .ce(ce), .vin(vin), .dpin(dpin),
    .x_out(x_out), .y_out(y_out));

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic a, input logic e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, a, e);
    end
  endtask

  function automatic logic [66:0] mk(input logic [31:0] lut, input logic [1:0] md,
      input logic [11:0] sf, input logic [11:0] sg, input logic [2:0] sm,
      input logic [1:0] dx, input logic [1:0] dy, input logic xs, input logic ys);
    return {lut, md, sf, sg, sm, dx, dy, xs, ys};
  endfunction

  function automatic logic pk(input logic [2:0] code, input logic [4:0] v,
                              input logic qx, input logic qy, input logic restr);
    if (code < 5) return v[code];
    if (restr) return 1'b0;
    if (code == 5) return qx;
    if (code == 6) return qy;
    return 1'b0;
  endfunction

  function automatic logic [1:0] model(input logic [66:0] c, input logic [4:0] v,
                                       input logic qx, input logic qy);
    logic [31:0] lut; logic [1:0] md; logic split, s, lo, hi, f, g;
    logic [3:0] fa, ga;
    lut = c[66:35]; md = c[34:33];
    split = (md == 2'd1) || (md == 2'd2);
    for (int i = 0; i < 4; i++) begin
      fa[i] = pk(c[21+3*i +: 3], v, qx, qy, split && i < 2);
      ga[i] = pk(c[9+3*i +: 3], v, qx, qy, split && i < 2);
    end
    s  = pk(c[8:6], v, qx, qy, 1'b0);
    lo = lut[{1'b0, fa}];
    hi = lut[{1'b1, ga}];
    case (md)
      2'd1:    begin f = lo; g = hi; end
      2'd2:    begin f = s ? hi : lo; g = f; end
      default: begin f = lut[{s, fa}]; g = f; end
    endcase
    return {f, g};
  endfunction

  function automatic logic dsel(input logic [1:0] d, input logic f, input logic g, input logic p);
    return (d == 2'd0) ? f : (d == 2'd1) ? g : p;
  endfunction

  task automatic load(input logic [66:0] c, input logic ce_v);
    for (int i = 66; i >= 0; i--) begin
      @(negedge clk); cfg_en = 1; cfg_din = c[i]; ce = ce_v; dpin = 0;
    end
    @(negedge clk); cfg_en = 0; ce = 0;
    sh = c;
  endtask

  task automatic step(input logic [4:0] v, input logic c_e, input logic d_i, input string tg);
    logic [1:0] fg; logic ex, ey; string t;
    @(negedge clk); vin = v; ce = c_e; dpin = d_i; #1;
    fg = model(sh, v, mqx, mqy);
    ex = sh[1] ? mqx : fg[1];
    ey = sh[0] ? mqy : fg[0];
    if (tg != "") t = tg;
    else case (sh[34:33]) 2'd0: t = "R3"; 2'd1: t = "R4"; 2'd2: t = "R6"; default: t = "R7"; endcase
    chk(x_out === ex, sh[1] ? "R12 x" : {t, " x"}, x_out, ex);
    chk(y_out === ey, sh[0] ? "R12 y" : {t, " y"}, y_out, ey);
    if (c_e) begin
      mqx = dsel(sh[5:4], fg[1], fg[0], d_i);
      mqy = dsel(sh[3:2], fg[1], fg[0], d_i);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rl;
    repeat (3) @(negedge clk);
    rst = 0; #1;
    // R1 reset state
    chk(x_out === 1'b0, "R1 x", x_out, 1'b0);
    chk(y_out === 1'b0, "R1 y", y_out, 1'b0);

    // R2 single set bit lands at address 0 after MSB-first shift
    load(mk(32'h1, 2'd0, 12'o3210, 12'o0, 3'd4, 2'd0, 2'd0, 0, 0), 0);
    for (int v = 0; v < 32; v++) step(v[4:0], 0, 0, "R2");

    // R3 / R7 single and alternate single mode sweeps
    rl = $urandom;
    load(mk(rl, 2'd0, 12'o3210, 12'o0, 3'd4, 2'd0, 2'd1, 0, 0), 0);
    for (int v = 0; v < 32; v++) step(v[4:0], 0, 0, "R3");
    load(mk(rl, 2'd3, 12'o1234, 12'o0, 3'd0, 2'd0, 2'd1, 0, 0), 0);
    for (int v = 0; v < 32; v++) step(v[4:0], 0, 0, "R7");

    // R8 feedback sources and constant code
    load(mk(32'hAAAA_AAAA, 2'd0, 12'o7765, 12'o0, 3'd7, 2'd2, 2'd2, 0, 0), 0);
    for (int k = 0; k < 8; k++) step(5'd0, 1, k[0] ^ k[1], "R8");
    load(mk(32'hCCCC_CCCC, 2'd0, 12'o7765, 12'o0, 3'd7, 2'd2, 2'd2, 0, 0), 0);
    for (int k = 0; k < 8; k++) step(5'd0, 1, k[1], "R8");

    // R5 restricted low address bits in split and merged modes
    rl = $urandom;
    load(mk(rl, 2'd1, 12'o7565, 12'o3265, 3'd0, 2'd2, 2'd2, 0, 0), 0);
    for (int v = 0; v < 32; v++) step(v[4:0], 1, v[0] ^ v[3], "R5");
    load(mk(rl, 2'd2, 12'o7565, 12'o3256, 3'd5, 2'd2, 2'd2, 0, 0), 0);
    for (int v = 0; v < 32; v++) step(v[4:0], 1, v[1] ^ v[2], "R5");

    // R9 each register data select, with ce toggling
    for (int d = 0; d < 4; d++) begin
      load(mk($urandom, 2'd1, 12'o3210, 12'o0123, 3'd4, d[1:0], 2'(3 - d), 1, 1), 0);
      for (int v = 0; v < 32; v++) step(v[4:0], v[0] | v[2], v[1], "R9");
    end

    // R11 ce held high through a full load must not change QX
    load(mk(32'h0, 2'd0, 12'o3210, 12'o0, 3'd4, 2'd2, 2'd2, 1, 1), 0);
    step(5'd0, 1, 1, "R11");
    load(mk(32'h0, 2'd0, 12'o3210, 12'o0, 3'd4, 2'd2, 2'd2, 1, 1), 1);
    step(5'd0, 0, 0, "R11");

    // R10 asynchronous clear, observed between clock edges
    @(negedge clk); clr = 1; #1;
    mqx = 0; mqy = 0;
    chk(x_out === 1'b0, "R10 x", x_out, 1'b0);
    chk(y_out === 1'b0, "R10 y", y_out, 1'b0);
    @(negedge clk); clr = 0;
    step(5'd0, 0, 0, "R10");

    // R12 and all modes under pseudo-random configurations
    for (int n = 0; n < 40; n++) begin
      load({$urandom, $urandom, 3'($urandom)}, 0);
      for (int v = 0; v < 32; v++) step(v[4:0], 1'($urandom), 1'($urandom), "");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule